// File: doc/BRIEF.md
# Receive Queue Index and Address Controller

This block keeps the bookkeeping of a circular receive queue whose elements are stored in a shared, word-addressed message RAM. It does not hold message data. It keeps a put index, a get index and a fill level. From these it produces a full status and three sticky interrupt flags: watermark reached, queue filled and message lost. It also turns each index into a RAM word address. That address is a configurable start address plus the index times the element size in words. The element size comes from a 3-bit data-field code.

Upstream acceptance logic pulses a store strobe for every message it wants to place in the queue. The write address shows where that element goes. The host reads the element at the read address and pulses an acknowledge to release it. Software clears the interrupt flags by writing ones.

Top module: `rxq_index_ctl`

## Requirements
- R1: After reset the put index, get index and fill level are 0, and the full status and all three interrupt flags are 0.
- R2: A store accepted while the queue is not full moves the put index to (put+1) modulo the depth and raises the fill level by one. The depth is 1 to 64 elements, and indices are 6 bits wide.
- R3: An acknowledge on a non-empty queue moves the get index to (get+1) modulo the depth and lowers the fill level by one. An acknowledge on an empty queue changes nothing.
- R4: A store and an acknowledge in the same cycle on a queue that is neither empty nor full both take effect, and the fill level does not change.
- R5: The full status is 1 exactly when the fill level equals the depth, which is when the put index has caught up with the get index. A store that makes the queue full sets the sticky full flag.
- R6: A store that arrives while the queue is full is dropped without moving any index, and it sets the sticky message-lost flag. An acknowledge in the same cycle still takes effect.
- R7: A store that raises the fill level to the 7-bit watermark value sets the sticky watermark flag. A watermark of 0, or one above the depth, never sets it.
- R8: The clear input has one bit per flag: bit 0 is watermark, bit 1 is full and bit 2 is lost. A 1 on a bit clears that flag. If the flag is set and cleared in the same cycle, the set wins.
- R9: The element size in words for data-field codes 0 to 7 is 4, 5, 6, 7, 8, 10, 14 and 18.
- R10: The write address is start + put×size, and the read address is start + get×size. The start address is 14 bits wide. The addresses are combinational from the current indices and configuration.
- R11: At depth 64 the queue holds 64 elements, with a fill level of 64 in a 7-bit count, and both indices wrap from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 7 | Queue depth in elements, 1 to 64 |
| cfg_wmark | input | 7 | Watermark fill level; 0 disables it |
| cfg_start | input | 14 | Queue start word address in message RAM |
| cfg_dsize | input | 3 | Data-field size code |
| store_i | input | 1 | Store one element (from acceptance logic) |
| ack_i | input | 1 | Host releases the oldest element |
| irq_clr_i | input | 3 | Write-1-to-clear for watermark, full and lost flags |
| wr_addr_o | output | 15 | RAM word address for the next store |
| rd_addr_o | output | 15 | RAM word address of the oldest element |
| put_idx_o | output | 6 | Put index |
| get_idx_o | output | 6 | Get index |
| fill_o | output | 7 | Number of elements held |
| full_o | output | 1 | Queue full status |
| irq_wm_o | output | 1 | Sticky watermark flag |
| irq_full_o | output | 1 | Sticky full flag |
| irq_lost_o | output | 1 | Sticky message-lost flag |

## Verification
The assertions assume that the depth, watermark, start address and size code only change while the block is held in reset. This keeps both indices below the depth and makes the address stride constant. The bench respects this: it pulses reset before every change of configuration, and it drives store, acknowledge and clear only through the cycle task. Strobes are single-cycle requests and may appear in any combination, including on an empty or a full queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Bit positions of the flag clear vector
    localparam int FLG_WM   = 0;
    localparam int FLG_FULL = 1;
    localparam int FLG_LOST = 2;
    localparam int FLG_N    = 3;

    localparam int WORDS_W  = 5;

    // Data-field code to element size in RAM words (header words included)
    function automatic logic [WORDS_W-1:0] elem_words(input logic [2:0] code);
        logic [WORDS_W-1:0] w;
        case (code)
            3'd0:    w = 5'd4;
            3'd1:    w = 5'd5;
            3'd2:    w = 5'd6;
            3'd3:    w = 5'd7;
            3'd4:    w = 5'd8;
            3'd5:    w = 5'd10;
            3'd6:    w = 5'd14;
            default: w = 5'd18;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rxq_wrap_inc.sv
module rxq_wrap_inc #(
    parameter int W = 6
) (
    input  logic [W-1:0] idx_i,
    input  logic [W-1:0] last_i,
    output logic [W-1:0] nxt_o
);
    always_comb begin
        if (idx_i >= last_i) nxt_o = '0;
        else                 nxt_o = idx_i + W'(1);
    end
endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen #(
    parameter int IDX_W   = 6,
    parameter int SA_W    = 14,
    parameter int WORDS_W = 5,
    parameter int AD_W    = 15
) (
    input  logic [SA_W-1:0]    start_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [WORDS_W-1:0] words_i,
    output logic [AD_W-1:0]    addr_o
);
    logic [IDX_W+WORDS_W-1:0] offs;

    always_comb begin
        offs   = IDX_W'(idx_i) * WORDS_W'(words_i);
        addr_o = AD_W'(start_i) + AD_W'(offs);
    end
endmodule

// File: rtl/rxq_index_ctl.sv
module rxq_index_ctl
    import rxq_pkg::*;
#(
    parameter  int MAX_DEPTH = 64,
    parameter  int SA_W      = 14,
    localparam int IDX_W     = $clog2(MAX_DEPTH),
    localparam int LVL_W     = $clog2(MAX_DEPTH + 1),
    localparam int AD_W      = $clog2((1 << SA_W) + MAX_DEPTH * 18)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  cfg_depth,
    input  logic [LVL_W-1:0]  cfg_wmark,
    input  logic [SA_W-1:0]   cfg_start,
    input  logic [2:0]        cfg_dsize,
    input  logic              store_i,
    input  logic              ack_i,
    input  logic [FLG_N-1:0]  irq_clr_i,
    output logic [AD_W-1:0]   wr_addr_o,
    output logic [AD_W-1:0]   rd_addr_o,
    output logic [IDX_W-1:0]  put_idx_o,
    output logic [IDX_W-1:0]  get_idx_o,
    output logic [LVL_W-1:0]  fill_o,
    output logic              full_o,
    output logic              irq_wm_o,
    output logic              irq_full_o,
    output logic              irq_lost_o
);

    typedef struct packed {
        logic [IDX_W-1:0] put;
        logic [IDX_W-1:0] get;
        logic [LVL_W-1:0] fill;
        logic             wm;
        logic             full;
        logic             lost;
    } state_t;

    state_t q, d;

    logic [LVL_W-1:0]   depth_c;
    logic [IDX_W-1:0]   last_c;
    logic [IDX_W-1:0]   put_nxt, get_nxt;
    logic [WORDS_W-1:0] words_c;
    logic [LVL_W-1:0]   fill_inc;
    logic               full_c, empty_c, do_st, do_ack, wm_en;
    logic               wm_hit, full_hit, lost_hit;

    // Effective depth clamped into 1..MAX_DEPTH
    always_comb begin
        if (cfg_depth == '0)                      depth_c = LVL_W'(1);
        else if (cfg_depth > LVL_W'(MAX_DEPTH))   depth_c = LVL_W'(MAX_DEPTH);
        else                                      depth_c = cfg_depth;
        last_c  = IDX_W'(depth_c - LVL_W'(1));
        words_c = elem_words(cfg_dsize);
    end

    // Index increment modulo depth for both pointers
    logic [IDX_W-1:0] ptr_cur [2];
    logic [IDX_W-1:0] ptr_nxt [2];
    logic [AD_W-1:0]  ptr_adr [2];

    assign ptr_cur[0] = q.put;
    assign ptr_cur[1] = q.get;

    for (genvar i = 0; i < 2; i++) begin : g_ptr
        rxq_wrap_inc #(.W(IDX_W)) u_inc (
            .idx_i  (ptr_cur[i]),
            .last_i (last_c),
            .nxt_o  (ptr_nxt[i])
        );
        rxq_addr_gen #(
            .IDX_W   (IDX_W),
            .SA_W    (SA_W),
            .WORDS_W (WORDS_W),
            .AD_W    (AD_W)
        ) u_adr (
            .start_i (cfg_start),
            .idx_i   (ptr_cur[i]),
            .words_i (words_c),
            .addr_o  (ptr_adr[i])
        );
    end

    assign put_nxt = ptr_nxt[0];
    assign get_nxt = ptr_nxt[1];

    // Next-state computation
    always_comb begin
        d        = q;
        fill_inc = q.fill + LVL_W'(1);
        full_c   = (q.fill >= depth_c);
        empty_c  = (q.fill == '0);
        do_st    = store_i && !full_c;
        do_ack   = ack_i && !empty_c;
        wm_en    = (cfg_wmark != '0) && (cfg_wmark <= depth_c);

        if (do_st)  d.put = put_nxt;
        if (do_ack) d.get = get_nxt;

        case ({do_st, do_ack})
            2'b10:   d.fill = fill_inc;
            2'b01:   d.fill = q.fill - LVL_W'(1);
            default: d.fill = q.fill;
        endcase

        wm_hit   = wm_en && do_st && !do_ack && (fill_inc == cfg_wmark);
        full_hit = do_st && !do_ack && (fill_inc == depth_c);
        lost_hit = store_i && full_c;

        d.wm   = wm_hit   | (q.wm   & ~irq_clr_i[FLG_WM]);
        d.full = full_hit | (q.full & ~irq_clr_i[FLG_FULL]);
        d.lost = lost_hit | (q.lost & ~irq_clr_i[FLG_LOST]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_addr_o  = ptr_adr[0];
    assign rd_addr_o  = ptr_adr[1];
    assign put_idx_o  = q.put;
    assign get_idx_o  = q.get;
    assign fill_o     = q.fill;
    assign full_o     = full_c;
    assign irq_wm_o   = q.wm;
    assign irq_full_o = q.full;
    assign irq_lost_o = q.lost;

    // ---------------- assertions ----------------
    p_fill_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= depth_c);

    p_full_meets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (put_idx_o == get_idx_o));

    p_store_sets_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !ack_i && !full_o && (fill_o == depth_c - LVL_W'(1))) |=> (full_o && irq_full_o));

    p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && full_o) |=> ($stable(put_idx_o) && irq_lost_o));

    p_empty_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !store_i && fill_o == '0) |=> ($stable(get_idx_o) && fill_o == '0));

    p_both_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && ack_i && !full_o && fill_o != '0) |=> $stable(fill_o));

    p_sticky_wm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wm_o && !irq_clr_i[FLG_WM]) |=> irq_wm_o);

    p_lost_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lost_o && irq_clr_i[FLG_LOST] && !store_i) |=> !irq_lost_o);

    p_stride_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (put_idx_o == get_idx_o) |-> (wr_addr_o == rd_addr_o));

endmodule

// File: tb/sim_rxq_index_ctl.sv
`timescale 1ns/1ps
module sim_rxq_index_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_depth = 7'd4;
    logic [6:0]  cfg_wmark = 7'd0;
    logic [13:0] cfg_start = 14'd0;
    logic [2:0]  cfg_dsize = 3'd0;
    logic        store_i = 1'b0;
    logic        ack_i = 1'b0;
    logic [2:0]  irq_clr_i = 3'd0;
    logic [14:0] wr_addr_o, rd_addr_o;
    logic [5:0]  put_idx_o, get_idx_o;
    logic [6:0]  fill_o;
    logic        full_o, irq_wm_o, irq_full_o, irq_lost_o;

    always #4 clk = ~clk;

    rxq_index_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_wmark(cfg_wmark),
        .cfg_start(cfg_start), .cfg_dsize(cfg_dsize), .store_i(store_i), .ack_i(ack_i),
        .irq_clr_i(irq_clr_i), .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o),
        .put_idx_o(put_idx_o), .get_idx_o(get_idx_o), .fill_o(fill_o), .full_o(full_o),
        .irq_wm_o(irq_wm_o), .irq_full_o(irq_full_o), .irq_lost_o(irq_lost_o)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int m_put, m_get, m_fill, m_wm, m_full, m_lost;

    function automatic int size_words(int code);
        int bytes;
        bytes = (code < 5) ? 8 + 4 * code : (code == 5 ? 32 : (code == 6 ? 48 : 64));
        return 2 + bytes / 4;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int w;
        w = size_words(int'(cfg_dsize));
        chk("R2", "put", put_idx_o, m_put);
        chk("R3", "get", get_idx_o, m_get);
        chk("R4", "fill", fill_o, m_fill);
        chk("R5", "full", full_o, (m_fill == cfg_depth) ? 1 : 0);
        chk("R5", "irq_full", irq_full_o, m_full);
        chk("R6", "irq_lost", irq_lost_o, m_lost);
        chk("R7", "irq_wm", irq_wm_o, m_wm);
        chk("R10", "wr_addr", wr_addr_o, int'(cfg_start) + m_put * w);
        chk("R10", "rd_addr", rd_addr_o, int'(cfg_start) + m_get * w);
    endtask

    task automatic do_reset(int dep, int wm, int start, int code);
        rst_n = 1'b0;
        store_i = 0; ack_i = 0; irq_clr_i = 0;
        cfg_depth = 7'(dep); cfg_wmark = 7'(wm); cfg_start = 14'(start); cfg_dsize = 3'(code);
        m_put = 0; m_get = 0; m_fill = 0; m_wm = 0; m_full = 0; m_lost = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one cycle: compare at negedge, drive, update model at posedge
    task automatic step(bit st, bit ak, bit [2:0] clr);
        int dep, wm;
        bit full, dost, doak;
        compare_all();
        store_i = st; ack_i = ak; irq_clr_i = clr;
        @(posedge clk);
        dep  = int'(cfg_depth);
        wm   = int'(cfg_wmark);
        full = (m_fill >= dep);
        dost = st && !full;
        doak = ak && (m_fill != 0);
        m_wm   = ((dost && !doak && wm >= 1 && wm <= dep && m_fill + 1 == wm) || (m_wm && !clr[0])) ? 1 : 0;
        m_full = ((dost && !doak && m_fill + 1 == dep) || (m_full && !clr[1])) ? 1 : 0;
        m_lost = ((st && full) || (m_lost && !clr[2])) ? 1 : 0;
        if (dost) m_put = (m_put + 1) % dep;
        if (doak) m_get = (m_get + 1) % dep;
        m_fill = m_fill + int'(dost) - int'(doak);
        @(negedge clk);
        store_i = 0; ack_i = 0; irq_clr_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(4, 3, 100, 0);
        chk("R1", "put", put_idx_o, 0);
        chk("R1", "get", get_idx_o, 0);
        chk("R1", "fill", fill_o, 0);
        chk("R1", "flags", {full_o, irq_wm_o, irq_full_o, irq_lost_o}, 0);

        // R2 R5 R6 R7: fill depth 4, overflow once
        for (int i = 0; i < 5; i++) step(1, 0, 3'b000);
        compare_all();
        chk("R6", "lost after overflow", irq_lost_o, 1);
        chk("R5", "full status", full_o, 1);
        // R6: store while full plus ack: ack applies, store dropped
        step(1, 1, 3'b000);
        chk("R6", "put held", put_idx_o, 0);
        chk("R6", "fill after ack", fill_o, 3);
        // R8: clear all flags
        step(0, 0, 3'b111);
        chk("R8", "flags cleared", {irq_wm_o, irq_full_o, irq_lost_o}, 0);
        // R4: simultaneous store and ack mid-level
        for (int i = 0; i < 6; i++) step(1, 1, 3'b000);
        chk("R4", "fill stable", fill_o, 3);
        // R3: drain past empty
        for (int i = 0; i < 5; i++) step(0, 1, 3'b000);
        chk("R3", "empty fill", fill_o, 0);
        // empty with both strobes: only the store
        step(1, 1, 3'b000);
        chk("R4", "empty both", fill_o, 1);
        compare_all();

        // R8: set and clear in the same cycle, set wins
        do_reset(2, 2, 7, 1);
        step(1, 0, 3'b000);
        step(1, 0, 3'b011);
        chk("R8", "full set beats clear", irq_full_o, 1);
        chk("R8", "wm set beats clear", irq_wm_o, 1);
        step(1, 0, 3'b100);
        chk("R8", "lost set beats clear", irq_lost_o, 1);
        compare_all();

        // R11: depth 64, largest element, wrap
        do_reset(64, 64, 16383, 7);
        for (int i = 0; i < 64; i++) step(1, 0, 3'b000);
        chk("R11", "fill 64", fill_o, 64);
        chk("R7", "wm at 64", irq_wm_o, 1);
        chk("R11", "put wrapped", put_idx_o, 0);
        step(1, 0, 3'b000);
        chk("R6", "lost at 64", irq_lost_o, 1);
        for (int i = 0; i < 63; i++) step(0, 1, 3'b000);
        chk("R10", "rd addr idx63", rd_addr_o, 16383 + 63 * 18);
        step(1, 1, 3'b000);
        chk("R11", "get wrapped", get_idx_o, 0);
        compare_all();

        // R7: disabled watermark values
        do_reset(3, 0, 0, 2);
        for (int i = 0; i < 3; i++) step(1, 0, 3'b000);
        chk("R7", "wm 0 disabled", irq_wm_o, 0);
        do_reset(3, 4, 0, 2);
        for (int i = 0; i < 4; i++) step(1, 0, 3'b000);
        chk("R7", "wm beyond depth disabled", irq_wm_o, 0);
        compare_all();

        // depth 1 corner
        do_reset(1, 1, 50, 3);
        step(1, 0, 3'b000);
        chk("R5", "depth1 full", full_o, 1);
        step(1, 1, 3'b000);
        chk("R2", "depth1 put", put_idx_o, 0);
        compare_all();

        // R9: every size code
        for (int c = 0; c < 8; c++) begin
            do_reset(8, 0, 200, c);
            step(1, 0, 3'b000);
            step(1, 0, 3'b000);
            chk("R9", "stride", int'(wr_addr_o) - 200, 2 * size_words(c));
            chk("R9", "stride rd", int'(rd_addr_o), 200);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule